// File: doc/BRIEF.md
# Multiphase PWM Phase Sequencer

This block is the digital sequencing stage of a multiphase buck controller. A pulse on the oscillator input starts each switching cycle. On that pulse the block raises the logic-level drive output of the next phase in the rotation. A pulse on the current-comparator input ends the on-time of that phase early. Only one drive output is ever high, and every phase gets one oscillator period out of each rotation. The phase count therefore sets a per-phase duty ceiling of 1/N.

A mode input selects the rotation length. Low gives two phases and high gives three. A new mode value is taken only when the rotation wraps back to the first phase, so no phase is cut short or repeated. An inhibit input from protection logic forces every output low and freezes the rotation. When inhibit is released, the rotation starts again at the first phase.

Top module: `phase_rotor`

## Requirements
- R1: An oscillator pulse (`tick` high for one cycle, `inhibit` low) drives exactly one bit of `phaseDrive` high in the following cycle, and `phaseIdx` gives that bit's position (0 = PWM1, 1 = PWM2, 2 = PWM3).
- R2: `trip` high while `tick` is low drops `phaseDrive` to all zeros in the next cycle. `phaseIdx` keeps its value. When `trip` and `tick` are both high in the same cycle, the pulse wins and the next phase is raised.
- R3: With the mode latched low, successive pulses alternate bit 0 and bit 1, and bit 2 is never raised.
- R4: With the mode latched high, successive pulses raise bits 0, 1, 2, 0, … in that order.
- R5: At most one bit of `phaseDrive` is high in any cycle.
- R6: While `inhibit` is high, `phaseDrive` is all zeros from the next cycle on, `phaseIdx` reads 0, and pulses on `tick` have no effect.
- R7: If no trip arrives before the next pulse, the same clock edge lowers the current phase and raises the next one.
- R8: After reset, `phaseDrive` is zero and `phaseIdx` is 0. The first pulse after reset, or after inhibit is released, raises bit 0.
- R9: `wideMode` is sampled only on a pulse that starts a rotation at bit 0. A change in the middle of a rotation first takes effect at the next wrap.
- R10: With evenly spaced pulses and no trips, each phase is high for at most 1/N of the cycles, where N is 2 in narrow mode and 3 in wide mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Oscillator pulse that starts a switching cycle |
| trip | input | 1 | Current-comparator trip that ends the on-time |
| wideMode | input | 1 | Phase-count select: 0 = two phases, 1 = three phases |
| inhibit | input | 1 | Protection override that forces all outputs low |
| phaseDrive | output | NUM_PH | One-hot drive outputs; bit 0 is PWM1 |
| phaseIdx | output | $clog2(NUM_PH) | Position of the most recently raised phase |

## Verification
Some properties are checked on every cycle: the outputs stay one-hot, a phase rises only after a pulse, a non-inhibited pulse always raises a phase, a trip or an inhibit clears the outputs, and the index always points at the bit that is high. Other behaviour can only be shown by the bench's scenarios, because it depends on history: the rotation order in each mode, a mode change that waits for the wrap, the restart at the first phase after inhibit, and the measured share of high cycles per phase against the 1/N ceiling.

// File: rtl/phase_rotor_pkg.sv
package phase_rotor_pkg;

  // Strobes issued by the control half to the datapath half each cycle
  typedef struct packed {
    logic advance;   // raise the next phase
    logic restart;   // next advance begins a fresh rotation at phase 0
    logic cut;       // end the current on-time
    logic halt;      // protection override, clear and freeze
  } rotorStrobes_t;

endpackage

// File: rtl/phase_rotor_ctrl.sv
module phase_rotor_ctrl
  import phase_rotor_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          tick,
  input  logic          trip,
  input  logic          inhibit,
  output rotorStrobes_t strobes
);

  logic startPend;

  // A pulse outranks a trip in the same cycle; inhibit outranks both
  always_comb begin
    strobes.halt    = inhibit;
    strobes.advance = tick && !inhibit;
    strobes.cut     = trip && !tick && !inhibit;
    strobes.restart = startPend;
  end

  // Remember that the rotation must begin again at phase 0
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        startPend <= 1'b1;
    else if (inhibit) startPend <= 1'b1;
    else if (tick)    startPend <= 1'b0;
  end

endmodule

// File: rtl/phase_rotor_dp.sv
module phase_rotor_dp
  import phase_rotor_pkg::*;
#(
  parameter  int NUM_PH = 3,
  localparam int IDX_W  = $clog2(NUM_PH)
) (
  input  logic                clk,
  input  logic                rstN,
  input  rotorStrobes_t       strobes,
  input  logic                wideMode,
  output logic [NUM_PH-1:0]   phaseDrive,
  output logic [IDX_W-1:0]    phaseIdx
);

  localparam logic [IDX_W-1:0] LAST_WIDE   = IDX_W'(NUM_PH - 1);
  localparam logic [IDX_W-1:0] LAST_NARROW = IDX_W'(NUM_PH - 2);

  logic              modeReg;
  logic [IDX_W-1:0]  idxReg;
  logic [NUM_PH-1:0] driveReg;
  logic [IDX_W-1:0]  lastIdx;
  logic              wrap;
  logic [IDX_W-1:0]  nextIdx;
  logic [NUM_PH-1:0] hotVec;

  assign lastIdx = modeReg ? LAST_WIDE : LAST_NARROW;
  assign wrap    = strobes.restart || (idxReg >= lastIdx);
  assign nextIdx = wrap ? '0 : idxReg + IDX_W'(1);

  // One-hot decode of the phase about to be raised
  for (genvar k = 0; k < NUM_PH; k++) begin : g_hot
    assign hotVec[k] = (nextIdx == IDX_W'(k));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeReg  <= 1'b0;
      idxReg   <= '0;
      driveReg <= '0;
    end else if (strobes.halt) begin
      idxReg   <= '0;
      driveReg <= '0;
    end else if (strobes.advance) begin
      idxReg   <= nextIdx;
      driveReg <= hotVec;
      if (wrap) modeReg <= wideMode;
    end else if (strobes.cut) begin
      driveReg <= '0;
    end
  end

  assign phaseDrive = driveReg;
  assign phaseIdx   = idxReg;

endmodule

// File: rtl/phase_rotor.sv
module phase_rotor
  import phase_rotor_pkg::*;
#(
  parameter  int NUM_PH = 3,
  localparam int IDX_W  = $clog2(NUM_PH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              trip,
  input  logic              wideMode,
  input  logic              inhibit,
  output logic [NUM_PH-1:0] phaseDrive,
  output logic [IDX_W-1:0]  phaseIdx
);

  rotorStrobes_t strobes;

  phase_rotor_ctrl ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .tick    (tick),
    .trip    (trip),
    .inhibit (inhibit),
    .strobes (strobes)
  );

  phase_rotor_dp #(.NUM_PH(NUM_PH)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .wideMode   (wideMode),
    .phaseDrive (phaseDrive),
    .phaseIdx   (phaseIdx)
  );

endmodule

// File: rtl/phase_rotor_chk.sv
module phase_rotor_chk #(
  parameter  int NUM_PH = 3,
  localparam int IDX_W  = $clog2(NUM_PH)
) (
  input logic              clk,
  input logic              rstN,
  input logic              tick,
  input logic              trip,
  input logic              inhibit,
  input logic [NUM_PH-1:0] phaseDrive,
  input logic [IDX_W-1:0]  phaseIdx
);

  // R5
  onehot_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(phaseDrive));

  // R1
  tick_raise_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tick && !inhibit) |=> (phaseDrive != '0));

  // R1
  raise_needs_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((phaseDrive != '0) && !$stable(phaseDrive)) |-> $past(tick));

  // R2
  trip_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (trip && !tick) |=> (phaseDrive == '0));

  // R6
  inhibit_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    inhibit |=> ((phaseDrive == '0) && (phaseIdx == '0)));

  // R1
  idx_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phaseDrive != '0) |-> phaseDrive[phaseIdx]);

endmodule

bind phase_rotor phase_rotor_chk #(.NUM_PH(NUM_PH)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .tick       (tick),
  .trip       (trip),
  .inhibit    (inhibit),
  .phaseDrive (phaseDrive),
  .phaseIdx   (phaseIdx)
);

// File: tb/phase_rotor_tb_top.sv
`timescale 1ns/1ps
module phase_rotor_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tick = 1'b0;
  logic       trip = 1'b0;
  logic       wideMode = 1'b0;
  logic       inhibit = 1'b0;
  logic [2:0] phaseDrive;
  logic [1:0] phaseIdx;

  always #2.5 clk = ~clk;

  phase_rotor #(.NUM_PH(3)) dut_i (
    .clk(clk), .rstN(rstN), .tick(tick), .trip(trip),
    .wideMode(wideMode), .inhibit(inhibit),
    .phaseDrive(phaseDrive), .phaseIdx(phaseIdx)
  );

  typedef struct packed { logic [2:0] drv; logic [1:0] idx; } item_t;
  item_t expQ[$];
  item_t monItem;

  int nCmp = 0;
  int nBad = 0;
  bit done = 0;

  // reference model state, from the requirements
  bit mStart = 1;
  int mIdx = 0;
  bit mWide = 0;

  int hi[3];
  int win;

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  endtask

  task automatic checkVal(input string tag, input int act, input int exp);
    nCmp++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // driver: predicts the result of one pulse and pushes it to the scoreboard
  task automatic issueTick(input bit withTrip);
    item_t e;
    if (inhibit) e = '0;
    else begin
      if (mStart || mIdx >= (mWide ? 2 : 1)) begin
        mIdx = 0; mWide = wideMode; mStart = 0;
      end else mIdx++;
      e.idx = 2'(mIdx);
      e.drv = 3'(1 << mIdx);
    end
    expQ.push_back(e);
    tick = 1'b1; trip = withTrip;
    @(negedge clk);
    tick = 1'b0; trip = 1'b0;
  endtask

  task automatic gap(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic acc();
    for (int k = 0; k < 3; k++) hi[k] += int'(phaseDrive[k]);
    win++;
  endtask

  // monitor: compares design output one cycle after each pulse
  logic tickQ = 1'b0;
  always @(posedge clk) tickQ <= tick;

  always @(negedge clk) begin
    if (tickQ) begin
      nCmp++;
      if (expQ.size() == 0) begin
        nBad++;
        $display("FAIL R1 unexpected pulse result act=%b exp=none", phaseDrive);
      end else begin
        monItem = expQ.pop_front();
        if (phaseDrive !== monItem.drv || phaseIdx !== monItem.idx) begin
          nBad++;
          $display("FAIL R1/R3/R4/R7/R9 rotation act drive=%b idx=%0d exp drive=%b idx=%0d",
                   phaseDrive, phaseIdx, monItem.drv, monItem.idx);
        end
      end
    end
  end

  initial begin
    repeat (40000) @(posedge clk);
    nCmp++; nBad++;
    $display("FAIL R1 watchdog act=hung exp=finished");
    finishRun();
  end

  initial begin
    gap(3);
    // R8 reset state
    checkVal("R8 reset drive", int'(phaseDrive), 0);
    checkVal("R8 reset idx", int'(phaseIdx), 0);
    rstN = 1'b1;
    gap(2);

    // R3 narrow rotation, first pulse from reset gives bit 0 (R8)
    wideMode = 1'b0;
    for (int t = 0; t < 5; t++) begin issueTick(0); gap(3); end

    // R2 trip ends on-time, index kept
    issueTick(0); gap(1);
    trip = 1'b1; @(negedge clk); trip = 1'b0;
    checkVal("R2 trip drops drive", int'(phaseDrive), 0);
    checkVal("R2 trip keeps idx", int'(phaseIdx), mIdx);
    gap(2);
    // R2 pulse and trip together: pulse wins
    issueTick(1); gap(3);

    // R9 mode change mid-rotation waits for wrap, then R4 wide order
    wideMode = 1'b1;
    for (int t = 0; t < 6; t++) begin issueTick(0); gap(3); end
    checkVal("R9 wide mode latched", int'(mWide), 1);

    // R10 duty ceiling, wide mode
    for (int k = 0; k < 3; k++) hi[k] = 0;
    win = 0;
    for (int t = 0; t < 12; t++) begin
      issueTick(0); acc();
      for (int c = 0; c < 3; c++) begin @(negedge clk); acc(); end
    end
    for (int k = 0; k < 3; k++)
      checkVal($sformatf("R10 wide share phase %0d within 1/3", k),
               int'(hi[k] * 3 <= win), 1);

    // R9 back to narrow in the middle of a rotation
    wideMode = 1'b0;
    for (int t = 0; t < 6; t++) begin issueTick(0); gap(3); end

    // R10 duty ceiling, narrow mode; R3 bit 2 never raised
    for (int k = 0; k < 3; k++) hi[k] = 0;
    win = 0;
    for (int t = 0; t < 8; t++) begin
      issueTick(0); acc();
      for (int c = 0; c < 3; c++) begin @(negedge clk); acc(); end
    end
    for (int k = 0; k < 2; k++)
      checkVal($sformatf("R10 narrow share phase %0d within 1/2", k),
               int'(hi[k] * 2 <= win), 1);
    checkVal("R3 PWM3 idle in narrow mode", hi[2], 0);

    // R6 inhibit clears and freezes
    issueTick(0); gap(1);
    inhibit = 1'b1;
    @(negedge clk);
    checkVal("R6 inhibit drive", int'(phaseDrive), 0);
    checkVal("R6 inhibit idx", int'(phaseIdx), 0);
    issueTick(0); gap(2);
    checkVal("R6 pulse ignored under inhibit", int'(phaseDrive), 0);
    inhibit = 1'b0;
    mStart = 1; mIdx = 0;
    gap(1);
    // R8 restart at PWM1 after release
    issueTick(0);
    checkVal("R8 restart at PWM1", int'(phaseDrive), 1);
    gap(3);
    issueTick(0); gap(3);

    gap(2);
    checkVal("R1 scoreboard drained", expQ.size(), 0);
    finishRun();
  end

endmodule